// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits in front of a single-port, synchronous-read data SRAM and serves two processor request ports. Each request names a byte address, a source operand, an access kind (plain load, plain store or atomic operation), an operation code and a size flag. For an atomic operation, the unit does four things in order. It reads the addressed word and merges the source operand into the old value with the chosen function. It writes the result back to the same location. It then returns the old value to the requester. Bit set, bit clear, bit toggle and in-place counter increments therefore cannot be corrupted by the other core.

Every access, plain or atomic, passes through one fixed-priority arbiter. A request is accepted only while the unit is idle, and the grant stays with its owner until the response has gone out. The other port's access therefore never lands between the read and the write. A 32-bit operation works on one half of the 64-bit word, picked by address bit 2. It writes that half through byte enables, leaves the other half as it was, and returns the old half sign-extended to 64 bits.

Top module: `amo_rmw_unit`

## Requirements
- R1: Operation codes 000 SWAP (write operand), 001 ADD, 010 XOR, 011 AND, 100 OR produce the stated 64-bit result, which is written back to the addressed word.
- R2: Code 101 writes the signed minimum and code 110 the signed maximum of the old value and the operand.
- R3: The response data is the memory value read before the update, and a later load of the same address returns the written-back result.
- R4: A 32-bit access uses address bit 2 to select the upper (1) or lower (0) half. The other half of the word stays unchanged.
- R5: A 32-bit access returns the selected old half sign-extended to 64 bits, and treats both operands as signed 32-bit numbers for MIN, MAX and ADD.
- R6: The response is a one-cycle pulse on the requesting port's resp_valid bit, four clock edges after the accepting edge.
- R7: From the accepting edge until the response cycle has passed, neither req_ready bit is high, so no other access can enter a sequence in progress.
- R8: When both ports are valid in the same idle cycle, port 0 is granted. Port 1 holds its request and is granted in the idle cycle after port 0's response.
- R9: Kind 00 (and 11) is a load that returns the word and writes nothing. Kind 01 is a store that writes the operand and returns the old value. Kind 10 is an atomic operation.
- R10: After reset, no resp_valid bit is high, and the idle unit raises req_ready for a valid request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, one bit per port |
| req_ready | output | 2 | Request accepted this cycle, one bit per port |
| req_kind | input | 2x2 | Access kind per port (00 load, 01 store, 10 atomic) |
| req_op | input | 2x3 | Operation code per port |
| req_w32 | input | 2 | 1 selects a 32-bit access, per port |
| req_addr | input | 2xAW | Byte address per port, 4-byte aligned |
| req_src | input | 2x64 | Source operand per port |
| resp_valid | output | 2 | One-cycle response pulse to the owning port |
| resp_data | output | 64 | Old memory value, sign-extended for 32-bit accesses |

## Verification
The bench builds the unit with the default AW of 6, which gives an eight-word memory. Random traffic from either port therefore keeps returning to the same words and to both halves of each. It can show a 32-bit write leaking into the wrong half, or a plain store or load from one core reaching a word while the other core's atomic operation on it is still in flight. A directed case raises both ports in the same cycle on one counter, so the stall of port 1 and the order of the two additions show up in the returned old values.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam int DW = 64;
    localparam int BE = DW / 8;

    typedef enum logic [2:0] {
        OP_SWAP = 3'b000,
        OP_ADD  = 3'b001,
        OP_XOR  = 3'b010,
        OP_AND  = 3'b011,
        OP_OR   = 3'b100,
        OP_MIN  = 3'b101,
        OP_MAX  = 3'b110
    } amo_op_e;

    typedef enum logic [1:0] {
        K_LOAD  = 2'b00,
        K_STORE = 2'b01,
        K_AMO   = 2'b10
    } amo_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_MODIFY, S_WRITE, S_RESPOND
    } amo_state_e;
endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
    parameter int NPORT = 2
) (
    input  logic             idle,
    input  logic [NPORT-1:0] valid,
    output logic [NPORT-1:0] grant,
    output logic [$clog2(NPORT)-1:0] pick
);
    always_comb begin
        grant = '0;
        pick  = '0;
        if (idle) begin
            for (int i = NPORT - 1; i >= 0; i--) begin
                if (valid[i]) begin
                    grant = '0;
                    grant[i] = 1'b1;
                    pick = i[$clog2(NPORT)-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  logic [2:0]    op,
    input  logic          w32,
    input  logic          half,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] old_ret,
    output logic [DW-1:0] wr_word
);
    logic [31:0]   old_half;
    logic [DW-1:0] a, b, r;

    always_comb begin
        old_half = half ? old_word[63:32] : old_word[31:0];
        a = w32 ? {{32{old_half[31]}}, old_half} : old_word;
        b = w32 ? {{32{src[31]}}, src[31:0]} : src;
        case (op)
            OP_ADD:  r = a + b;
            OP_XOR:  r = a ^ b;
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_MIN:  r = ($signed(a) < $signed(b)) ? a : b;
            OP_MAX:  r = ($signed(a) < $signed(b)) ? b : a;
            default: r = b;
        endcase
        old_ret = a;
        wr_word = w32 ? {r[31:0], r[31:0]} : r;
    end
endmodule

// File: rtl/amo_sram.sv
module amo_sram
    import amo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic          we,
    input  logic [BE-1:0] be,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[idx];
        if (we) begin
            for (int i = 0; i < BE; i++) begin
                if (be[i]) mem[idx][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    p_port_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(re && we));
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int AW = 6,
    localparam int NPORT = 2,
    localparam int DEPTH = 2 ** (AW - 3),
    localparam int IW = AW - 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0]           req_valid,
    output logic [NPORT-1:0]           req_ready,
    input  logic [NPORT-1:0][1:0]      req_kind,
    input  logic [NPORT-1:0][2:0]      req_op,
    input  logic [NPORT-1:0]           req_w32,
    input  logic [NPORT-1:0][AW-1:0]   req_addr,
    input  logic [NPORT-1:0][DW-1:0]   req_src,
    output logic [NPORT-1:0]           resp_valid,
    output logic [DW-1:0]              resp_data
);
    typedef struct packed {
        amo_state_e st;
        logic       owner;
        logic [1:0] kind;
        logic [2:0] op;
        logic       w32;
        logic [AW-1:0] addr;
        logic [DW-1:0] src;
        logic [DW-1:0] old;
        logic [DW-1:0] res;
    } ctx_t;

    ctx_t cur_q, nxt_d;

    logic          pick;
    logic [DW-1:0] rdata, alu_old, alu_wr;
    logic          mem_re, mem_we;
    logic [BE-1:0] mem_be;

    amo_arbiter #(.NPORT(NPORT)) u_arb (
        .idle  (cur_q.st == S_IDLE),
        .valid (req_valid),
        .grant (req_ready),
        .pick  (pick)
    );

    amo_alu u_alu (
        .op       (cur_q.op),
        .w32      (cur_q.w32),
        .half     (cur_q.addr[2]),
        .old_word (rdata),
        .src      (cur_q.src),
        .old_ret  (alu_old),
        .wr_word  (alu_wr)
    );

    amo_sram #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (mem_re),
        .we    (mem_we),
        .be    (mem_be),
        .idx   (cur_q.addr[AW-1:3]),
        .wdata (cur_q.res),
        .rdata (rdata)
    );

    always_comb begin
        nxt_d  = cur_q;
        mem_re = 1'b0;
        mem_we = 1'b0;
        mem_be = cur_q.w32 ? (cur_q.addr[2] ? 8'hF0 : 8'h0F) : 8'hFF;
        resp_valid = '0;
        resp_data  = '0;
        case (cur_q.st)
            S_IDLE: begin
                if (|req_ready) begin
                    nxt_d.owner = pick;
                    nxt_d.kind  = req_kind[pick];
                    nxt_d.op    = (req_kind[pick] == K_STORE) ? OP_SWAP : req_op[pick];
                    nxt_d.w32   = req_w32[pick];
                    nxt_d.addr  = req_addr[pick];
                    nxt_d.src   = req_src[pick];
                    nxt_d.st    = S_READ;
                end
            end
            S_READ: begin
                mem_re   = 1'b1;
                nxt_d.st = S_MODIFY;
            end
            S_MODIFY: begin
                nxt_d.old = alu_old;
                nxt_d.res = alu_wr;
                nxt_d.st  = S_WRITE;
            end
            S_WRITE: begin
                mem_we   = (cur_q.kind == K_STORE) || (cur_q.kind == K_AMO);
                nxt_d.st = S_RESPOND;
            end
            S_RESPOND: begin
                resp_valid[cur_q.owner] = 1'b1;
                resp_data = cur_q.old;
                nxt_d.st  = S_IDLE;
            end
            default: nxt_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            cur_q.st <= S_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    p_locked_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_valid & req_ready)) |=> (req_ready == '0) ##1 (req_ready == '0)
        ##1 (req_ready == '0) ##1 (resp_valid != '0));
    p_port0_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid[0] && req_ready[1]));
    p_resp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|resp_valid) |=> (resp_valid == '0));
    p_resp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_valid));
    p_grant_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
endmodule

// File: tb/amo_rmw_unit_test.sv
`timescale 1ns/1ps
module amo_rmw_unit_test;
    localparam int AW = 6;
    localparam int WORDS = 2 ** (AW - 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req_valid = '0;
    logic [1:0] req_ready;
    logic [1:0][1:0] req_kind = '0;
    logic [1:0][2:0] req_op = '0;
    logic [1:0] req_w32 = '0;
    logic [1:0][AW-1:0] req_addr = '0;
    logic [1:0][63:0] req_src = '0;
    logic [1:0] resp_valid;
    logic [63:0] resp_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] model_mem [WORDS];

    always #2 clk = ~clk;

    amo_rmw_unit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_op(req_op), .req_w32(req_w32), .req_addr(req_addr),
        .req_src(req_src), .resp_valid(resp_valid), .resp_data(resp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void ref_op(input logic [1:0] kind, input logic [2:0] op, input logic w32,
                                   input logic half, input logic [63:0] old, input logic [63:0] src,
                                   output logic [63:0] ret, output logic [63:0] nw);
        logic [63:0] a, b, r;
        logic [31:0] h;
        h = half ? old[63:32] : old[31:0];
        a = w32 ? {{32{h[31]}}, h} : old;
        b = w32 ? {{32{src[31]}}, src[31:0]} : src;
        case ((kind == 2'b01) ? 3'b000 : op)
            3'b001: r = a + b;
            3'b010: r = a ^ b;
            3'b011: r = a & b;
            3'b100: r = a | b;
            3'b101: r = ($signed(a) < $signed(b)) ? a : b;
            3'b110: r = ($signed(a) > $signed(b)) ? a : b;
            default: r = b;
        endcase
        ret = a;
        if (kind == 2'b00 || kind == 2'b11) nw = old;
        else if (!w32) nw = r;
        else if (half) nw = {r[31:0], old[31:0]};
        else nw = {old[63:32], r[31:0]};
    endfunction

    // Drive one request on port c at a negedge, wait for grant, follow it to the response.
    task automatic run_one(input int c, input logic [1:0] kind, input logic [2:0] op, input logic w32,
                           input logic [AW-1:0] addr, input logic [63:0] src, input string req);
        logic [63:0] exp_ret, nw;
        int idx;
        idx = int'(addr[AW-1:3]);
        ref_op(kind, op, w32, addr[2], model_mem[idx], src, exp_ret, nw);
        req_valid[c] = 1'b1; req_kind[c] = kind; req_op[c] = op;
        req_w32[c] = w32; req_addr[c] = addr; req_src[c] = src;
        #0.5;
        chk(req_ready[c] == 1'b1, "R10 ready when idle", 64'(req_ready), 64'(2'b1 << c));
        @(posedge clk);
        @(negedge clk);
        req_valid[c] = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            chk(req_ready == 2'b00 && resp_valid == 2'b00, "R7 locked, no early response",
                64'({req_ready, resp_valid}), 64'd0);
            @(negedge clk);
        end
        chk(resp_valid == (2'b1 << c), "R6 response on 4th edge", 64'(resp_valid), 64'(2'b1 << c));
        chk(resp_data == exp_ret, req, resp_data, exp_ret);
        model_mem[idx] = nw;
        @(negedge clk);
        chk(resp_valid == 2'b00, "R6 one-cycle pulse", 64'(resp_valid), 64'd0);
    endtask

    task automatic verify_word(input int idx, input string req);
        run_one(0, 2'b00, 3'b000, 1'b0, AW'(idx << 3), 64'd0, req);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] base;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < WORDS; i++) model_mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(resp_valid == 2'b00, "R10 reset response low", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(resp_valid == 2'b00 && req_ready == 2'b00, "R10 idle outputs", 64'({req_ready, resp_valid}), 64'd0);

        // Fill memory with plain stores (R9).
        for (int i = 0; i < WORDS; i++)
            run_one(i % 2, 2'b01, 3'b111, 1'b0, AW'(i << 3), {$urandom, $urandom}, "R9 store returns old");
        for (int i = 0; i < WORDS; i++) verify_word(i, "R3 store written back");

        // Directed 64-bit operations (R1, R2).
        run_one(0, 2'b01, 3'b000, 1'b0, 6'h08, 64'h00FF_0000_F0F0_1234, "R9 store");
        run_one(0, 2'b10, 3'b100, 1'b0, 6'h08, 64'h0000_0001_0000_0001, "R1 OR sets bits");
        run_one(0, 2'b10, 3'b011, 1'b0, 6'h08, ~64'h0000_0000_0000_1000, "R1 AND clears bits");
        run_one(0, 2'b10, 3'b010, 1'b0, 6'h08, 64'hFFFF_0000_0000_0000, "R1 XOR toggles bits");
        run_one(1, 2'b10, 3'b001, 1'b0, 6'h08, 64'd1, "R1 ADD increments");
        run_one(1, 2'b10, 3'b000, 1'b0, 6'h08, 64'h8000_0000_0000_0005, "R1 SWAP");
        run_one(1, 2'b10, 3'b101, 1'b0, 6'h08, 64'd3, "R2 MIN keeps negative");
        run_one(1, 2'b10, 3'b110, 1'b0, 6'h08, 64'd3, "R2 MAX picks positive");
        run_one(0, 2'b10, 3'b001, 1'b0, 6'h08, 64'hFFFF_FFFF_FFFF_FFFF, "R1 ADD wraps");
        verify_word(1, "R3 result written back");

        // 32-bit halves (R4, R5).
        run_one(0, 2'b01, 3'b000, 1'b0, 6'h10, 64'h1111_2222_8000_0007, "R9 store");
        run_one(0, 2'b10, 3'b001, 1'b1, 6'h10, 64'h0000_0000_0000_0001, "R5 lower half sign-extended");
        run_one(0, 2'b10, 3'b101, 1'b1, 6'h14, 64'h0000_0000_FFFF_FFFF, "R5 signed 32-bit MIN");
        run_one(1, 2'b10, 3'b110, 1'b1, 6'h10, 64'h0000_0000_0000_0009, "R5 signed 32-bit MAX");
        run_one(1, 2'b00, 3'b000, 1'b1, 6'h14, 64'd0, "R4 upper half load");
        run_one(1, 2'b11, 3'b000, 1'b0, 6'h10, 64'd0, "R9 kind 11 loads");
        verify_word(2, "R4 other half unchanged");

        // Both ports at once on one counter (R8).
        base = model_mem[3];
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            req_valid[c] = 1'b1; req_kind[c] = 2'b10; req_op[c] = 3'b001;
            req_w32[c] = 1'b0; req_addr[c] = 6'h18; req_src[c] = 64'(c + 5);
        end
        #0.5;
        chk(req_ready == 2'b01, "R8 port 0 wins", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid[0] = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            chk(req_ready == 2'b00, "R8 port 1 stalled", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        chk(resp_valid == 2'b01 && resp_data == base, "R8 port 0 old value", resp_data, base);
        @(negedge clk);
        chk(req_ready == 2'b10, "R8 port 1 granted next idle", 64'(req_ready), 64'd2);
        @(posedge clk);
        @(negedge clk);
        req_valid[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk(resp_valid == 2'b10 && resp_data == base + 64'd5, "R8 port 1 sees port 0 update",
            resp_data, base + 64'd5);
        model_mem[3] = base + 64'd11;
        @(negedge clk);
        verify_word(3, "R8 both additions applied");

        // Random mix from both ports.
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            logic [1:0] kd;
            a = AW'({$urandom % WORDS, 1'($urandom), 2'b00});
            kd = 2'($urandom % 3);
            run_one(int'($urandom % 2), kd, 3'($urandom % 7), 1'($urandom), a,
                    {$urandom, $urandom}, "R3 random old value");
        end
        for (int i = 0; i < WORDS; i++) verify_word(i, "R4 random final contents");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule